// File: doc/BRIEF.md
# Floating-Point Status Word Unit

This block keeps the 32-bit status word of a coprocessor-style floating-point unit. When an operation completes, the datapath pulses `op_valid` for one cycle. With it come the operation's class, the classified result (sign, zero, infinity, not-a-number), the quotient sign and the low quotient magnitude bits from a modulo or remainder step, and the set of exception flags that the operation raised. The block then updates three fields, each by its own rule:

- The condition-code nibble is reloaded by every arithmetic operation.
- The quotient field is sticky. Only modulo and remainder operations overwrite it.
- The exception byte is replaced by every operation that can raise exceptions, and left alone by moves that cannot.

Software reads and writes the whole word through a simple register port, and a software write wins over an operation update in the same cycle. The raw flags N, Z, I and NaN are stored as they are. Four combinational outputs derive the IEEE comparison relations from them, so a library routine can test for special operands directly and still branch on ordered compares.

Top module: `fpstat_unit`

## Requirements
- R1: On `op_valid` with class ARITH (code 0) or MODREM (code 1), the condition nibble is loaded from the result classification, in this layout: bit 27 holds N (the sign), bit 26 holds Z, bit 25 holds I (infinity), bit 24 holds NaN.
- R2: When the result is NaN, only N (from the sign) and NaN are set, and Z and I read 0. When both zero and infinity are presented without NaN, Z is set and I is cleared, so Z and I are never set together after an operation.
- R3: Classes STORE (code 2), MULTI (code 3) and CTRL (code 4) leave bits 27–24 unchanged.
- R4: On MODREM, bit 23 takes the quotient sign and bits 22–16 take the seven-bit quotient magnitude.
- R5: Every other class, and every idle cycle, leaves bits 23–16 unchanged until software overwrites them.
- R6: Classes ARITH, MODREM and STORE replace bits 15–8 with the raised flags. The order from bit 15 down is branch-on-unordered, signalling NaN, operand error, overflow, underflow, divide-by-zero, inexact result, inexact input. Flags that are not raised read 0.
- R7: Classes MULTI and CTRL, the unused codes 5–7, and any cycle with `op_valid` low leave bits 15–8 unchanged.
- R8: Bits 7–0 (accrued byte) change only through a software write. Bits 31–28 always read 0.
- R9: When `sw_we` is high, the next word equals `sw_wdata` with bits 31–28 cleared, even if an operation completes in the same cycle.
- R10: The predicates are derived from the stored nibble: `pred_eq` = Z, `pred_un` = NaN, `pred_gt` = no NaN, no Z and no N, and `pred_lt` = N with no NaN and no Z.
- R11: A synchronous active-high `rst` clears the whole word on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe marking a completed operation |
| op_class | input | 3 | Operation class code (0 ARITH, 1 MODREM, 2 STORE, 3 MULTI, 4 CTRL) |
| res_sign | input | 1 | Result sign |
| res_zero | input | 1 | Result is zero |
| res_inf | input | 1 | Result is infinity |
| res_nan | input | 1 | Result is NaN or unordered |
| quo_sign | input | 1 | Sign of the whole quotient |
| quo_mag | input | 7 | Seven low bits of the unsigned quotient |
| exc_flags | input | 8 | Raised exception flags, same order as bits 15–8 |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 32 | Software write data |
| status_word | output | 32 | Current status word |
| pred_eq | output | 1 | Equal relation |
| pred_un | output | 1 | Unordered relation |
| pred_gt | output | 1 | Greater-than relation |
| pred_lt | output | 1 | Less-than relation |

## Verification
The properties assume that a class code, result flags, quotient and exception flags are only meaningful while `op_valid` is high. They also assume that software may write any pattern, including Z and I together, so the Z/I exclusion is checked only in the cycle after an operation that has no software write beside it. The stimulus keeps `op_valid` to single-cycle pulses and drives every input on the falling edge. It deliberately presents inconsistent classifications (zero with infinity, NaN with zero) and unused class codes, so that the priority and hold rules are exercised without breaking those assumptions.

// File: rtl/fpstat_pkg.sv
package fpstat_pkg;

    localparam int WORD_W  = 32;
    localparam int CC_W    = 4;
    localparam int QMAG_W  = 7;
    localparam int QUO_W   = QMAG_W + 1;
    localparam int EXC_W   = 8;
    localparam int ACC_W   = 8;
    localparam int ACC_LSB = 0;
    localparam int EXC_LSB = ACC_LSB + ACC_W;
    localparam int QUO_LSB = EXC_LSB + EXC_W;
    localparam int CC_LSB  = QUO_LSB + QUO_W;
    localparam int RSV_LSB = CC_LSB + CC_W;
    localparam int RSV_W   = WORD_W - RSV_LSB;

    typedef enum logic [2:0] {
        OPC_ARITH  = 3'd0,
        OPC_MODREM = 3'd1,
        OPC_STORE  = 3'd2,
        OPC_MULTI  = 3'd3,
        OPC_CTRL   = 3'd4
    } op_class_e;

    typedef struct packed {
        logic n;
        logic z;
        logic inf;
        logic nan;
    } cc_t;

    typedef struct packed {
        logic sign;
        logic zero;
        logic inf;
        logic nan;
    } res_class_t;

    typedef struct packed {
        logic              sign;
        logic [QMAG_W-1:0] mag;
    } quo_t;

    function automatic logic class_loads_cc(input logic [2:0] c);
        return (c == OPC_ARITH) || (c == OPC_MODREM);
    endfunction

    function automatic logic class_loads_quo(input logic [2:0] c);
        return c == OPC_MODREM;
    endfunction

    function automatic logic class_loads_exc(input logic [2:0] c);
        return (c == OPC_ARITH) || (c == OPC_MODREM) || (c == OPC_STORE);
    endfunction

    function automatic cc_t classify(input res_class_t r);
        cc_t c;
        c.n   = r.sign;
        c.nan = r.nan;
        c.z   = r.zero & ~r.nan;
        c.inf = r.inf & ~r.nan & ~r.zero;
        return c;
    endfunction

endpackage

// File: rtl/fpstat_field.sv
module fpstat_field #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_ld,
    input  logic [W-1:0] sw_val,
    input  logic         op_ld,
    input  logic [W-1:0] op_val,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (sw_ld) q <= sw_val;
        else if (op_ld) q <= op_val;
    end
endmodule

// File: rtl/fpstat_pred.sv
module fpstat_pred
    import fpstat_pkg::*;
(
    input  cc_t  cc,
    output logic eq,
    output logic un,
    output logic gt,
    output logic lt
);
    always_comb begin
        eq = cc.z;
        un = cc.nan;
        gt = ~(cc.nan | cc.z | cc.n);
        lt = cc.n & ~(cc.nan | cc.z);
    end
endmodule

// File: rtl/fpstat_unit.sv
module fpstat_unit
    import fpstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_class,
    input  logic              res_sign,
    input  logic              res_zero,
    input  logic              res_inf,
    input  logic              res_nan,
    input  logic              quo_sign,
    input  logic [QMAG_W-1:0] quo_mag,
    input  logic [EXC_W-1:0]  exc_flags,
    input  logic              sw_we,
    input  logic [WORD_W-1:0] sw_wdata,
    output logic [WORD_W-1:0] status_word,
    output logic              pred_eq,
    output logic              pred_un,
    output logic              pred_gt,
    output logic              pred_lt
);
    localparam int NFIELD = 4;
    localparam int FW_MAX = 8;

    res_class_t rcls;
    cc_t        cc_next;
    cc_t        cc_q;
    quo_t       quo_next;

    logic [NFIELD-1:0]              op_ld;
    logic [NFIELD-1:0][FW_MAX-1:0]  op_val;
    logic [NFIELD-1:0][FW_MAX-1:0]  sw_val;
    logic [NFIELD-1:0][FW_MAX-1:0]  fq;

    localparam int FIELD_W   [NFIELD] = '{CC_W, QUO_W, EXC_W, ACC_W};
    localparam int FIELD_LSB [NFIELD] = '{CC_LSB, QUO_LSB, EXC_LSB, ACC_LSB};

    always_comb begin
        rcls     = '{sign: res_sign, zero: res_zero, inf: res_inf, nan: res_nan};
        cc_next  = classify(rcls);
        quo_next = '{sign: quo_sign, mag: quo_mag};

        op_ld[0] = op_valid & class_loads_cc(op_class);
        op_ld[1] = op_valid & class_loads_quo(op_class);
        op_ld[2] = op_valid & class_loads_exc(op_class);
        op_ld[3] = 1'b0;

        op_val    = '0;
        op_val[0][CC_W-1:0]  = cc_next;
        op_val[1][QUO_W-1:0] = quo_next;
        op_val[2][EXC_W-1:0] = exc_flags;
    end

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        localparam int W   = FIELD_W[i];
        localparam int LSB = FIELD_LSB[i];
        logic [W-1:0] q_i;

        always_comb begin
            sw_val[i]        = '0;
            sw_val[i][W-1:0] = sw_wdata[LSB +: W];
            fq[i]            = '0;
            fq[i][W-1:0]     = q_i;
        end

        fpstat_field #(.W(W)) u_fld (
            .clk    (clk),
            .rst    (rst),
            .sw_ld  (sw_we),
            .sw_val (sw_val[i][W-1:0]),
            .op_ld  (op_ld[i]),
            .op_val (op_val[i][W-1:0]),
            .q      (q_i)
        );
    end

    always_comb begin
        cc_q        = cc_t'(fq[0][CC_W-1:0]);
        status_word = {{RSV_W{1'b0}},
                       fq[0][CC_W-1:0],
                       fq[1][QUO_W-1:0],
                       fq[2][EXC_W-1:0],
                       fq[3][ACC_W-1:0]};
    end

    fpstat_pred u_pred (
        .cc (cc_q),
        .eq (pred_eq),
        .un (pred_un),
        .gt (pred_gt),
        .lt (pred_lt)
    );
endmodule

// File: rtl/fpstat_unit_chk.sv
module fpstat_unit_chk
    import fpstat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [2:0]        op_class,
    input logic              res_sign,
    input logic              res_zero,
    input logic              res_inf,
    input logic              res_nan,
    input logic              quo_sign,
    input logic [QMAG_W-1:0] quo_mag,
    input logic [EXC_W-1:0]  exc_flags,
    input logic              sw_we,
    input logic [WORD_W-1:0] sw_wdata,
    input logic [WORD_W-1:0] status_word,
    input logic              pred_eq,
    input logic              pred_un,
    input logic              pred_gt,
    input logic              pred_lt
);
    logic cc_keep, quo_keep, exc_keep, cc_op;

    always_comb begin
        cc_op    = op_valid && !sw_we && (op_class == OPC_ARITH || op_class == OPC_MODREM);
        cc_keep  = !sw_we && !(op_valid && (op_class == OPC_ARITH || op_class == OPC_MODREM));
        quo_keep = !sw_we && !(op_valid && op_class == OPC_MODREM);
        exc_keep = !sw_we && !(op_valid && (op_class == OPC_ARITH || op_class == OPC_MODREM
                                            || op_class == OPC_STORE));
    end

    // R1: an arithmetic op loads N and NaN straight from the result
    p_cc_load_r1: assert property (@(posedge clk) disable iff (rst)
        cc_op |=> status_word[27] == $past(res_sign) && status_word[24] == $past(res_nan));

    // R2: Z and I never set together after an operation
    p_zi_excl_r2: assert property (@(posedge clk) disable iff (rst)
        cc_op |=> !(status_word[26] && status_word[25]));

    // R3: condition nibble held by non-arithmetic classes
    p_cc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        cc_keep |=> $stable(status_word[27:24]));

    // R5: quotient sticky
    p_quo_hold_r5: assert property (@(posedge clk) disable iff (rst)
        quo_keep |=> $stable(status_word[23:16]));

    // R7: exception byte held by non-exception classes and idle cycles
    p_exc_hold_r7: assert property (@(posedge clk) disable iff (rst)
        exc_keep |=> $stable(status_word[15:8]));

    // R8: accrued byte only software-written; reserved bits zero
    p_acc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> $stable(status_word[7:0]));
    p_rsv_zero_r8: assert property (@(posedge clk) disable iff (rst)
        status_word[31:28] == 4'h0);

    // R9: software write has priority
    p_sw_prio_r9: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> status_word == ($past(sw_wdata) & 32'h0FFF_FFFF));

    // R10: greater and less are exclusive
    p_pred_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(pred_gt && pred_lt));

    // R11: reset clears the word
    p_reset_r11: assert property (@(posedge clk)
        rst |=> status_word == '0);
endmodule

bind fpstat_unit fpstat_unit_chk u_chk (.*);

// File: tb/fpstat_unit_tb.sv
module fpstat_unit_tb;
    import fpstat_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_class = '0;
    logic        res_sign = 1'b0, res_zero = 1'b0, res_inf = 1'b0, res_nan = 1'b0;
    logic        quo_sign = 1'b0;
    logic [6:0]  quo_mag = '0;
    logic [7:0]  exc_flags = '0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] status_word;
    logic        pred_eq, pred_un, pred_gt, pred_lt;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    fpstat_unit u_dut (.*);

    typedef struct packed {
        logic [2:0]  cls;
        logic        s, z, i, n;
        logic        qs;
        logic [6:0]  qm;
        logic [7:0]  exc;
        logic [31:0] exp_word;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 1'b1,1'b0,1'b0,1'b0, 1'b1,7'h55, 8'h02, 32'h0800_0200}, // R1 R6 negative normal
        '{3'd1, 1'b0,1'b1,1'b0,1'b0, 1'b1,7'h05, 8'h00, 32'h0485_0000}, // R4 modrem zero
        '{3'd2, 1'b1,1'b0,1'b0,1'b1, 1'b0,7'h11, 8'h20, 32'h0485_2000}, // R3 R5 R6 store
        '{3'd3, 1'b1,1'b0,1'b1,1'b0, 1'b0,7'h22, 8'hFF, 32'h0485_2000}, // R3 R7 multi
        '{3'd4, 1'b0,1'b0,1'b0,1'b1, 1'b1,7'h33, 8'h81, 32'h0485_2000}, // R3 R7 ctrl
        '{3'd0, 1'b1,1'b1,1'b1,1'b1, 1'b0,7'h00, 8'h80, 32'h0985_8000}, // R2 NaN masks Z,I
        '{3'd0, 1'b0,1'b1,1'b1,1'b0, 1'b0,7'h00, 8'h40, 32'h0485_4000}, // R2 zero beats inf
        '{3'd0, 1'b1,1'b0,1'b1,1'b0, 1'b0,7'h00, 8'h10, 32'h0A85_1000}, // R1 -inf
        '{3'd1, 1'b0,1'b0,1'b0,1'b0, 1'b0,7'h7F, 8'h01, 32'h007F_0100}, // R4 quotient max
        '{3'd7, 1'b1,1'b0,1'b1,1'b0, 1'b1,7'h01, 8'hAA, 32'h007F_0100}  // R7 unused code
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_pred(input string req);
        logic [3:0] exp;
        logic nn, zz, nan;
        nn = status_word[27]; zz = status_word[26]; nan = status_word[24];
        exp = {zz, nan, ~(nan | zz | nn), nn & ~(nan | zz)};
        check(req, {28'h0, pred_eq, pred_un, pred_gt, pred_lt}, {28'h0, exp});
    endtask

    task automatic do_op(input vec_t v, input logic with_sw, input logic [31:0] wd);
        op_class = v.cls; res_sign = v.s; res_zero = v.z; res_inf = v.i; res_nan = v.n;
        quo_sign = v.qs; quo_mag = v.qm; exc_flags = v.exc;
        op_valid = 1'b1; sw_we = with_sw; sw_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0; sw_we = 1'b0;
    endtask

    task automatic sw_write(input logic [31:0] wd);
        sw_we = 1'b1; sw_wdata = wd;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R11 reset word", status_word, 32'h0);
        check_pred("R10 reset predicates");

        for (int k = 0; k < NVEC; k++) begin
            do_op(VECS[k], 1'b0, 32'h0);
            check($sformatf("R1-table vec %0d", k), status_word, VECS[k].exp_word);
            check_pred($sformatf("R10 vec %0d", k));
        end

        // R7: inputs moving with op_valid low change nothing
        op_class = 3'd0; res_inf = 1'b1; exc_flags = 8'hFF; quo_mag = 7'h3C;
        repeat (2) @(negedge clk);
        check("R7 idle hold", status_word, 32'h007F_0100);

        // R8: reserved bits read zero after full write
        sw_write(32'hFFFF_FFFF);
        check("R8 reserved zero", status_word, 32'h0FFF_FFFF);

        // R8: operations leave accrued byte
        sw_write(32'h0000_005A);
        do_op(VECS[0], 1'b0, 32'h0);
        check("R8 accrued kept", status_word, 32'h0800_025A);

        // R9: software write wins over a simultaneous operation
        do_op(VECS[8], 1'b1, 32'h0123_4567);
        check("R9 sw priority", status_word, 32'h0123_4567);

        // R10 predicates from software-set nibbles
        sw_write(32'h0800_0000);
        check_pred("R10 less");
        check("R10 lt value", {31'h0, pred_lt}, 32'h1);
        sw_write(32'h0C00_0000);
        check_pred("R10 neg zero");
        check("R10 eq value", {31'h0, pred_eq}, 32'h1);
        sw_write(32'h0900_0000);
        check_pred("R10 nan");
        check("R10 un value", {30'h0, pred_un, pred_gt}, 32'h2);

        // R11: reset mid-run
        sw_write(32'h0FFF_FFFF);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 mid reset", status_word, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule